// File: doc/BRIEF.md
# Reservation Monitor for Atomic Read-Modify-Write Sequences

This block holds the reservation state that one processor uses for lock-free atomic updates built from a load-locked and a store-conditional. When a load-locked completes without a fault, the block records which naturally aligned 16-byte block of physical memory was read and raises its reservation flag. A later store-conditional may write only if the flag is still raised and its own physical address falls in that same block. Writes by other agents that are observed on the snoop port, and every store-conditional, drop the reservation.

The store-permit decision and the value returned to the store-conditional's destination register are combinational on the request. The cache, the memory system and address translation lie outside the block. They supply only completion, fault and address information.

Top module: `resv_monitor`

## Requirements
- R1: After reset the reservation flag is clear, so a store-conditional issued before any load-locked is refused (permit 0, result 0).
- R2: A load-locked completion (`ll_done` high, `ll_fault` low) records its address and raises the flag. A store-conditional to the same address in a later cycle is permitted and returns result 1.
- R3: The match ignores address bits 3:0 and compares bits PA_W-1:4 only. A store-conditional to any byte of the recorded 16-byte block succeeds.
- R4: A store-conditional whose bits PA_W-1:4 differ from the recorded block is refused (permit 0, result 0).
- R5: A load-locked completion with `ll_fault` high neither raises the flag nor changes an existing reservation.
- R6: Every store-conditional clears the flag whether it succeeds or not, so a second store-conditional to the same block is refused.
- R7: A snooped write whose bits PA_W-1:4 match the recorded block clears the flag. A snooped write to any other block leaves the reservation intact.
- R8: `sc_result` is zero-extended to RES_W bits. It is 1 exactly when `sc_permit` is 1 and is 0 otherwise. It is produced in the same cycle as the request, and both outputs are 0 when no store-conditional is requested.
- R9: A fault-free load-locked while a reservation is already held replaces the recorded block with the new one.
- R10: A fault-free load-locked completing in the same cycle as a store-conditional or a snoop hit leaves the flag raised afterwards. The store-conditional in that cycle is judged on the reservation held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_done | input | 1 | A load-locked completes this cycle |
| ll_fault | input | 1 | The completing load-locked faulted |
| ll_addr | input | PA_W | Physical address of the load-locked |
| sc_req | input | 1 | A store-conditional asks for a decision this cycle |
| sc_addr | input | PA_W | Physical address of the store-conditional |
| snp_valid | input | 1 | Another agent writes memory this cycle |
| snp_addr | input | PA_W | Physical address of the snooped write |
| sc_permit | output | 1 | The store may be performed |
| sc_result | output | RES_W | Value for the store-conditional destination register |

## Verification
Both `sc_permit` and `sc_result` are due in the cycle the store-conditional is presented. The bench therefore drives each request just after a falling edge and compares the outputs a short delay later, before the next rising edge. Load-locked, snoop and store-conditional effects on the reservation take hold at the rising edge that ends their cycle. They become visible only through a store-conditional presented in a following cycle, and every stateful check is sequenced that way.

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int PA_W    = 64,
  parameter int BLK_LSB = 4,
  parameter int RES_W   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ll_done,
  input  logic             ll_fault,
  input  logic [PA_W-1:0]  ll_addr,
  input  logic             sc_req,
  input  logic [PA_W-1:0]  sc_addr,
  input  logic             snp_valid,
  input  logic [PA_W-1:0]  snp_addr,
  output logic             sc_permit,
  output logic [RES_W-1:0] sc_result
);

  localparam int TAG_W = PA_W - BLK_LSB;

  logic             held_q;
  logic [TAG_W-1:0] tag_q;
  logic             arm;
  logic             snp_hit;

  assign arm     = ll_done & ~ll_fault;
  assign snp_hit = snp_valid & held_q & (snp_addr[PA_W-1:BLK_LSB] == tag_q);

  assign sc_permit = sc_req & held_q & (sc_addr[PA_W-1:BLK_LSB] == tag_q);
  assign sc_result = {{(RES_W-1){1'b0}}, sc_permit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      tag_q  <= '0;
    end else if (arm) begin
      held_q <= 1'b1;
      tag_q  <= ll_addr[PA_W-1:BLK_LSB];
    end else if (sc_req || snp_hit) begin
      held_q <= 1'b0;
    end
  end

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_req |-> (sc_permit == 1'b0 && sc_result == '0));

  p_permit_needs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_permit |-> held_q);

  p_arm_records_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (held_q && tag_q == $past(ll_addr[PA_W-1:BLK_LSB])));

  p_sc_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !arm) |=> !held_q);

  p_snoop_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && !arm) |=> !held_q);

  p_fault_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_done && ll_fault && !sc_req && !snp_valid) |=> ($stable(held_q) && $stable(tag_q)));

endmodule

// File: tb/sim_resv_monitor.sv
module sim_resv_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 64;
  localparam int RES_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ll_done = 1'b0, ll_fault = 1'b0, sc_req = 1'b0, snp_valid = 1'b0;
  logic [PA_W-1:0] ll_addr = '0, sc_addr = '0, snp_addr = '0;
  logic sc_permit;
  logic [RES_W-1:0] sc_result;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_monitor u0 (
    .clk(clk), .rst_n(rst_n),
    .ll_done(ll_done), .ll_fault(ll_fault), .ll_addr(ll_addr),
    .sc_req(sc_req), .sc_addr(sc_addr),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .sc_permit(sc_permit), .sc_result(sc_result)
  );

  task automatic check_out(input string req, input logic exp);
    n_chk++;
    if (sc_permit !== exp || sc_result !== {{(RES_W-1){1'b0}}, exp}) begin
      n_bad++;
      $display("FAIL %s: permit=%b result=%h expected permit=%b result=%0d",
               req, sc_permit, sc_result, exp, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    ll_done = 0; ll_fault = 0; sc_req = 0; snp_valid = 0;
  endtask

  task automatic do_ll(input logic [PA_W-1:0] a, input logic flt);
    @(negedge clk);
    ll_done = 1; ll_fault = flt; ll_addr = a;
    #1 check_out("R8", 1'b0);
    idle_cycle();
  endtask

  task automatic do_sc(input logic [PA_W-1:0] a, input logic exp, input string req);
    @(negedge clk);
    sc_req = 1; sc_addr = a;
    #1 check_out(req, exp);
    idle_cycle();
  endtask

  task automatic do_snoop(input logic [PA_W-1:0] a);
    @(negedge clk);
    snp_valid = 1; snp_addr = a;
    #1 check_out("R8", 1'b0);
    idle_cycle();
  endtask

  task automatic t_reset();
    do_sc(64'h0, 1'b0, "R1");
    do_sc(64'h1000, 1'b0, "R1");
  endtask

  task automatic t_arm_and_offsets();
    do_ll(64'h0000_1234_5678_9A40, 0);
    do_sc(64'h0000_1234_5678_9A40, 1'b1, "R2");
    do_ll(64'h0000_1234_5678_9A40, 0);
    do_sc(64'h0000_1234_5678_9A4F, 1'b1, "R3");
    do_ll(64'hFFFF_0000_0000_0008, 0);
    do_sc(64'hFFFF_0000_0000_0003, 1'b1, "R3");
  endtask

  task automatic t_mismatch();
    do_ll(64'h8000_0000_0000_0100, 0);
    do_sc(64'h8000_0000_0000_0110, 1'b0, "R4");
    do_ll(64'h8000_0000_0000_0100, 0);
    do_sc(64'h0000_0000_0000_0100, 1'b0, "R4");
  endtask

  task automatic t_fault();
    do_ll(64'h2000, 1);
    do_sc(64'h2000, 1'b0, "R5");
    do_ll(64'h3000, 0);
    do_ll(64'h4000, 1);
    do_sc(64'h3000, 1'b1, "R5");
  endtask

  task automatic t_sc_clears();
    do_ll(64'h5000, 0);
    do_sc(64'h6000, 1'b0, "R6");
    do_sc(64'h5000, 1'b0, "R6");
    do_ll(64'h5000, 0);
    do_sc(64'h5000, 1'b1, "R6");
    do_sc(64'h5000, 1'b0, "R6");
  endtask

  task automatic t_snoop();
    do_ll(64'h7000, 0);
    do_snoop(64'h7010);
    do_sc(64'h7000, 1'b1, "R7");
    do_ll(64'h7000, 0);
    do_snoop(64'h700C);
    do_sc(64'h7000, 1'b0, "R7");
  endtask

  task automatic t_replace();
    do_ll(64'h9000, 0);
    do_ll(64'hA000, 0);
    do_sc(64'h9000, 1'b0, "R9");
    do_ll(64'h9000, 0);
    do_ll(64'hA000, 0);
    do_sc(64'hA008, 1'b1, "R9");
  endtask

  task automatic t_same_cycle();
    do_ll(64'hB000, 0);
    @(negedge clk);
    ll_done = 1; ll_addr = 64'hC000; sc_req = 1; sc_addr = 64'hB004;
    #1 check_out("R10", 1'b1);
    idle_cycle();
    do_sc(64'hC000, 1'b1, "R10");
    do_ll(64'hD000, 0);
    @(negedge clk);
    ll_done = 1; ll_addr = 64'hD000; snp_valid = 1; snp_addr = 64'hD000;
    #1 check_out("R8", 1'b0);
    idle_cycle();
    do_sc(64'hD000, 1'b1, "R10");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_arm_and_offsets();
    t_mismatch();
    t_fault();
    t_sc_clears();
    t_snoop();
    t_replace();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule